// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM controller

This block sits between a synchronous host and an asynchronous static RAM module that is 32 bits wide and has 2^20 words. The memory gives each of its four bytes its own active-low select. The host issues one word per request over a valid/ready handshake: a 20-bit word address, a read/write flag, 32 bits of write data and a 4-bit byte mask. The controller then plays out the strobe sequence that the memory expects. Each step of that sequence lasts a whole number of controller clocks, derived from nanosecond parameters and a clock-period parameter. A read returns the word with a one-cycle valid pulse.

The memory data bus is split into three signals: an input, an output and an output enable, so a pad ring or a bench can close it. On a write, the data is set up before write enable falls and held after it rises. The write takes place while a lane select and write enable are both low. Every read is followed by turnaround cycles with all strobes released. These cycles give the memory time to let go of the bus before the controller can drive it again. Four presence-detect straps are sampled and turned into the log2 of the module depth.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after reset, all four lane selects, write enable and output enable are high, the data bus is not driven, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the access and any turnaround are complete. While `req_ready` is 1, no strobe is asserted and the bus is not driven.
- R3: A write holds `mem_cs_n[i]` low exactly for the lanes whose `req_mask[i]` is 1. Lane i is bits 8i+7..8i. The write runs for 1 setup cycle with write enable high, then 3 cycles with `mem_we_n` low, then 1 hold cycle with write enable high. All lanes are then released. Output enable stays high throughout.
- R4: On a write, `mem_dq_oe` is 1 and `mem_dq_out` carries the request data from the first setup cycle through the hold cycle, and at no other time. Write enable is never low unless the bus is driven.
- R5: A read holds the masked lane selects and `mem_oe_n` low for 3 cycles while write enable stays high. `rd_valid` is 1 for exactly the one cycle that follows.
- R6: `rd_data` holds the bus value sampled on the last read cycle for the selected lanes, and zero in every lane that was not selected.
- R7: After each read, 2 turnaround cycles with every strobe released pass before `req_ready` returns to 1.
- R8: `mem_depth_log2` reports 20 when the straps read {pd3,pd2,pd1,pd0} = 1,0,1,0, and 0 for every other strap pattern. It follows the straps with one register.
- R9: `mem_addr` shows the request address and does not change while any lane select is low.
- R10: The controller never drives the data bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte lanes taking part in the access |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` fresh |
| rd_data | output | 32 | Read word, unselected lanes zero |
| mem_addr | output | 20 | Memory address lines |
| mem_cs_n | output | 4 | Active-low lane selects, one per byte |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 32 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 32 | Data from the memory |
| mem_pd | input | 4 | Presence-detect straps, bit i = pd i |
| mem_depth_log2 | output | 5 | log2 of module words, 0 if unknown |

## Verification
All fifteen non-zero byte masks are first written over full-mask background words. Each address is then read back with a full mask and with its own mask. This separates correct lane steering from swapped, merged or ignored lanes. A memory model returns a filler byte on unselected lanes, so a missing zero fill shows up in the read data. The model also records writes only through the select and write-enable overlap, so a wrong select pattern or an undriven bus corrupts stored data. Every access is traced cycle by cycle against the phase lengths. A full sweep of the sixteen strap patterns shows that only the one coded pattern reports a depth.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WSU,
        ST_WP,
        ST_WH,
        ST_TURN
    } seq_state_e;

    // Nanoseconds-in-picoseconds to whole clock cycles, rounded up, at least one.
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LANES     = 4,
    parameter int unsigned CLK_PS    = 4000,
    parameter int unsigned T_ACC_PS  = 12000,
    parameter int unsigned T_WSU_PS  = 1000,
    parameter int unsigned T_WP_PS   = 10000,
    parameter int unsigned T_SD_PS   = 7000,
    parameter int unsigned T_WH_PS   = 1000,
    parameter int unsigned T_TA_PS   = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              cap_en,
    output logic [LANES-1:0]  cap_mask
);

    localparam int unsigned RD_C  = ps_to_cycles(T_ACC_PS, CLK_PS);
    localparam int unsigned WSU_C = ps_to_cycles(T_WSU_PS, CLK_PS);
    localparam int unsigned WP_C  = ps_to_cycles(max_u(T_WP_PS, T_SD_PS), CLK_PS);
    localparam int unsigned WH_C  = ps_to_cycles(T_WH_PS, CLK_PS);
    localparam int unsigned TA_C  = ps_to_cycles(T_TA_PS, CLK_PS);
    localparam int unsigned MAX_C = max_u(max_u(RD_C, WSU_C), max_u(max_u(WP_C, WH_C), TA_C));
    localparam int unsigned CNT_W = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
        logic [LANES-1:0]  cs_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.mask  = req_mask;
                    seq_d.cs_n  = ~req_mask;
                    if (req_write) begin
                        seq_d.st    = ST_WSU;
                        seq_d.cnt   = CNT_W'(WSU_C - 1);
                        seq_d.dq_oe = 1'b1;
                    end else begin
                        seq_d.st    = ST_RD;
                        seq_d.cnt   = CNT_W'(RD_C - 1);
                        seq_d.oe_n  = 1'b0;
                    end
                end
            end
            ST_RD: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.st   = ST_TURN;
                    seq_d.cnt  = CNT_W'(TA_C - 1);
                    seq_d.cs_n = '1;
                    seq_d.oe_n = 1'b1;
                end
            end
            ST_WSU: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.st   = ST_WP;
                    seq_d.cnt  = CNT_W'(WP_C - 1);
                    seq_d.we_n = 1'b0;
                end
            end
            ST_WP: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.st   = ST_WH;
                    seq_d.cnt  = CNT_W'(WH_C - 1);
                    seq_d.we_n = 1'b1;
                end
            end
            ST_WH: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.st    = ST_IDLE;
                    seq_d.cs_n  = '1;
                    seq_d.dq_oe = 1'b0;
                end
            end
            ST_TURN: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: begin
                seq_d.st    = ST_IDLE;
                seq_d.cs_n  = '1;
                seq_d.oe_n  = 1'b1;
                seq_d.we_n  = 1'b1;
                seq_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= ST_IDLE;
            seq_q.cnt   <= '0;
            seq_q.addr  <= '0;
            seq_q.wdata <= '0;
            seq_q.mask  <= '0;
            seq_q.cs_n  <= '1;
            seq_q.oe_n  <= 1'b1;
            seq_q.we_n  <= 1'b1;
            seq_q.dq_oe <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready  = (seq_q.st == ST_IDLE);
    assign mem_addr   = seq_q.addr;
    assign mem_cs_n   = seq_q.cs_n;
    assign mem_oe_n   = seq_q.oe_n;
    assign mem_we_n   = seq_q.we_n;
    assign mem_dq_out = seq_q.wdata;
    assign mem_dq_oe  = seq_q.dq_oe;
    assign cap_en     = (seq_q.st == ST_RD) && (seq_q.cnt == '0);
    assign cap_mask   = seq_q.mask;

endmodule

// File: rtl/sram_lane_gather.sv
module sram_lane_gather #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [LANES-1:0]  cap_mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned LANE_W = DATA_W / LANES;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } gather_regs_t;

    gather_regs_t g_d, g_q;
    logic [DATA_W-1:0] masked;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign masked[i*LANE_W +: LANE_W] = cap_mask[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        g_d       = g_q;
        g_d.valid = cap_en;
        if (cap_en) begin
            g_d.data = masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.valid <= 1'b0;
            g_q.data  <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign rd_valid = g_q.valid;
    assign rd_data  = g_q.data;

endmodule

// File: rtl/sram_depth_strap.sv
module sram_depth_strap #(
    parameter int unsigned PD_W     = 4,
    parameter logic [3:0]  PD_MATCH = 4'b1010,
    parameter int unsigned DEPTH    = 20,
    parameter int unsigned OUT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PD_W-1:0]  pd,
    output logic [OUT_W-1:0] depth_log2
);

    typedef struct packed {
        logic [OUT_W-1:0] depth;
    } strap_regs_t;

    strap_regs_t s_d, s_q;

    always_comb begin
        s_d.depth = (pd == PD_W'(PD_MATCH)) ? OUT_W'(DEPTH) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.depth <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign depth_log2 = s_q.depth;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned LANES    = 4,
    parameter int unsigned PD_W     = 4,
    parameter logic [3:0]  PD_MATCH = 4'b1010,
    parameter int unsigned CLK_PS   = 4000,
    parameter int unsigned T_ACC_PS = 12000,
    parameter int unsigned T_WSU_PS = 1000,
    parameter int unsigned T_WP_PS  = 10000,
    parameter int unsigned T_SD_PS  = 7000,
    parameter int unsigned T_WH_PS  = 1000,
    parameter int unsigned T_TA_PS  = 7000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [LANES-1:0]              req_mask,
    output logic                          rd_valid,
    output logic [DATA_W-1:0]             rd_data,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [LANES-1:0]              mem_cs_n,
    output logic                          mem_oe_n,
    output logic                          mem_we_n,
    output logic [DATA_W-1:0]             mem_dq_out,
    output logic                          mem_dq_oe,
    input  logic [DATA_W-1:0]             mem_dq_in,
    input  logic [PD_W-1:0]               mem_pd,
    output logic [$clog2(ADDR_W+1)-1:0]   mem_depth_log2
);

    localparam int unsigned DEPTH_W = $clog2(ADDR_W + 1);

    logic             cap_en;
    logic [LANES-1:0] cap_mask;

    sram_lane_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .CLK_PS(CLK_PS),
        .T_ACC_PS(T_ACC_PS), .T_WSU_PS(T_WSU_PS), .T_WP_PS(T_WP_PS),
        .T_SD_PS(T_SD_PS), .T_WH_PS(T_WH_PS), .T_TA_PS(T_TA_PS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .cap_en     (cap_en),
        .cap_mask   (cap_mask)
    );

    sram_lane_gather #(.DATA_W(DATA_W), .LANES(LANES)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_mask (cap_mask),
        .dq_in    (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    sram_depth_strap #(
        .PD_W(PD_W), .PD_MATCH(PD_MATCH), .DEPTH(ADDR_W), .OUT_W(DEPTH_W)
    ) u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd         (mem_pd),
        .depth_log2 (mem_depth_log2)
    );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    // R4: write enable low only while the bus is driven
    a_r4_we_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R10: never drive against the memory's outputs
    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5: valid is a single-cycle pulse
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R5: valid follows a cycle with output enable low
    a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n));

    // R9: address frozen while a lane is selected
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_cs_n != '1) && $past(mem_cs_n != '1)) |-> $stable(mem_addr));

    // R2: idle means quiet memory pins
    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((mem_cs_n == '1) && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;

    localparam int CLK_PS = 4000;
    localparam int RD_C   = (12000 + CLK_PS - 1) / CLK_PS;
    localparam int WSU_C  = (1000 + CLK_PS - 1) / CLK_PS;
    localparam int WP_C   = (10000 + CLK_PS - 1) / CLK_PS;
    localparam int WH_C   = (1000 + CLK_PS - 1) / CLK_PS;
    localparam int TA_C   = (7000 + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [19:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [31:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_in;
    logic [3:0]  mem_pd = 4'b1010;
    logic [4:0]  mem_depth_log2;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] model [16];
    logic [31:0] exp_mem [16];

    always #2 clk = ~clk;

    sram_lane_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_pd(mem_pd), .mem_depth_log2(mem_depth_log2)
    );

    // Memory model: writes land during select/write-enable overlap,
    // unselected lanes read back as filler 8'hA5.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) model[i] <= '0;
        end else if (!mem_we_n) begin
            for (int l = 0; l < 4; l++)
                if (!mem_cs_n[l])
                    model[mem_addr[3:0]][l*8 +: 8] <= mem_dq_oe ? mem_dq_out[l*8 +: 8] : 8'hEE;
        end
    end

    always_comb begin
        for (int l = 0; l < 4; l++)
            mem_dq_in[l*8 +: 8] = (!mem_oe_n && mem_we_n && !mem_cs_n[l])
                                  ? model[mem_addr[3:0]][l*8 +: 8] : 8'hA5;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_bits(input logic [3:0] m);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = m[l] ? 8'hFF : 8'h00;
        return r;
    endfunction

    task automatic report_and_end();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic issue(input bit wr, input logic [19:0] a, input logic [31:0] d,
                         input logic [3:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [19:0] a, input logic [31:0] d, input logic [3:0] m);
        bit ok3 = 1, ok4 = 1, ok2 = 1;
        logic [31:0] a3 = 0, e3 = 0, a4 = 0, e4 = 0;
        int total = WSU_C + WP_C + WH_C;
        issue(1'b1, a, d, m);
        for (int k = 1; k <= total + 1; k++) begin
            bit act = (k <= total);
            bit pulse = (k > WSU_C) && (k <= WSU_C + WP_C);
            logic [31:0] g3 = {26'd0, mem_cs_n, mem_we_n, mem_oe_n};
            logic [31:0] x3 = {26'd0, act ? ~m : 4'hF, ~pulse, 1'b1};
            if (ok3 && g3 !== x3) begin ok3 = 0; a3 = g3; e3 = x3; end
            if (ok4 && (mem_dq_oe !== act || (act && (mem_dq_out !== d || mem_addr !== a)))) begin
                ok4 = 0; a4 = {mem_dq_oe, 11'd0, mem_addr}; e4 = {act, 11'd0, a};
            end
            if (req_ready !== !act) ok2 = 0;
            if (k <= total) @(negedge clk);
        end
        chk(ok3, "R3", "write strobes {cs_n,we_n,oe_n}", a3, e3);
        chk(ok4, "R4", "write bus drive/addr (R9)", a4, e4);
        chk(ok2, "R2", "ready low during write", {31'd0, req_ready}, 32'd1);
        for (int l = 0; l < 4; l++)
            if (m[l]) exp_mem[a[3:0]][l*8 +: 8] = d[l*8 +: 8];
    endtask

    task automatic do_read(input logic [19:0] a, input logic [3:0] m);
        bit ok5 = 1, ok7 = 1;
        logic [31:0] a5 = 0, e5 = 0;
        logic [31:0] exp = exp_mem[a[3:0]] & lane_bits(m);
        issue(1'b0, a, 32'd0, m);
        for (int k = 1; k <= RD_C + TA_C + 1; k++) begin
            bit act = (k <= RD_C);
            logic [31:0] g = {20'd0, rd_valid, mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n, 4'd0};
            logic [31:0] x = {20'd0, (k == RD_C + 1), 1'b0, act ? ~m : 4'hF, 1'b1, !act, 4'd0};
            if (ok5 && (g !== x || (act && mem_addr !== a))) begin ok5 = 0; a5 = g; e5 = x; end
            if (k == RD_C + 1) chk(rd_data === exp, "R6", "read data", rd_data, exp);
            if (req_ready !== (k == RD_C + TA_C + 1)) ok7 = 0;
            if (k <= RD_C + TA_C) @(negedge clk);
        end
        chk(ok5, "R5", "read strobes/valid/addr (R9)", a5, e5);
        chk(ok7, "R7", "turnaround before ready", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report_and_end();
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1 && rd_valid === 1'b0, "R1", "ready/valid in reset",
            {30'd0, req_ready, rd_valid}, 32'd2);
        chk(mem_cs_n === 4'hF && mem_we_n === 1'b1 && mem_oe_n === 1'b1 && mem_dq_oe === 1'b0,
            "R1", "strobes in reset", {26'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe},
            {26'd0, 4'hF, 1'b1, 1'b1, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n === 4'hF && req_ready === 1'b1, "R1", "after reset release",
            {27'd0, mem_cs_n, req_ready}, {27'd0, 4'hF, 1'b1});

        // R8 strap sweep
        for (int p = 0; p < 16; p++) begin
            mem_pd = 4'(p);
            @(negedge clk); @(negedge clk);
            chk(mem_depth_log2 === ((p == 4'b1010) ? 5'd20 : 5'd0), "R8", "depth code",
                {27'd0, mem_depth_log2}, (p == 4'b1010) ? 32'd20 : 32'd0);
        end
        mem_pd = 4'b1010;

        // background full-mask writes
        for (int i = 1; i < 16; i++)
            do_write(20'((i << 12) | i), (32'(i) * 32'h01010101) ^ 32'hC3A55A3C, 4'hF);
        // partial-mask overwrites
        for (int m = 1; m < 16; m++)
            do_write(20'((m << 12) | m), ~((32'(m) * 32'h11111111) + 32'h0F1E2D3C), 4'(m));
        // readback: full mask, own mask, complementary mask
        for (int m = 1; m < 16; m++) begin
            do_read(20'((m << 12) | m), 4'hF);
            do_read(20'((m << 12) | m), 4'(m));
            if (m != 15) do_read(20'((m << 12) | m), ~4'(m));
        end
        // read then immediate write then read
        do_read(20'h0F00F, 4'h5);
        do_write(20'h0F00F, 32'hDEADBEEF, 4'hA);
        do_read(20'h0F00F, 4'hF);

        report_and_end();
    end

endmodule